// File: doc/BRIEF.md
# Hourly chime tone generator

This block drives the speaker pin of a digital clock's top-of-hour chime. It takes the system clock, a one-pulse-per-second strobe from the running clock, and that clock's BCD minute and second digits. From the system clock it derives two square-wave tones one octave apart. A schedule decoded from the time then picks which tone, if any, reaches the speaker.

Near the end of each hour, a short low-pitch beep sounds on every even second from minute 59 second 50 to second 58. The odd seconds between them are silent. When the minutes and seconds both read zero, one high-pitch beep sounds for that second. At every other time the speaker pin rests at 0.

The time digits are sampled only on the cycle the second strobe is high. Tone selection is made from that registered copy, and the speaker pin itself is a register, so the pin cannot glitch while the digits are changing.

Top module: `chime_gen`

## Requirements
- R1: A synchronous active-low reset clears both tone dividers and drives `spk_o` to 0 on the next clock edge. After reset, `spk_o` stays 0 until the first `sec_tick` has captured a time.
- R2: The low tone is a square wave that toggles every `LO_HALF` system clock cycles. The default of 25000 gives 1 kHz from a 50 MHz clock.
- R3: The high tone toggles every `LO_HALF/2` cycles, which is twice the low-tone frequency (12500 cycles, or 2 kHz, by default).
- R4: While the captured time is minute 59 (tens digit 5, units digit 9) and the seconds are 50, 52, 54, 56 or 58 (tens digit 5, even units digit), `spk_o` carries the low tone.
- R5: While the captured time is minute 59 and the seconds are 51, 53, 55, 57 or 59, `spk_o` is 0.
- R6: While the captured time is minute 00 and second 00 (all four digits 0), `spk_o` carries the high tone.
- R7: At every other captured time (for example 58:50, 59:48, 00:01 or 10:00), `spk_o` is held at 0.
- R8: The four BCD digit inputs are sampled only on cycles where `sec_tick` is 1. Changes to them on other cycles have no effect on `spk_o`.
- R9: `spk_o` is registered. It follows the schedule for a new time from the second clock edge after the `sec_tick` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per second; the digit inputs are valid on this cycle |
| min_tens | input | 4 | BCD tens digit of minutes |
| min_ones | input | 4 | BCD units digit of minutes |
| sec_tens | input | 4 | BCD tens digit of seconds |
| sec_ones | input | 4 | BCD units digit of seconds |
| spk_o | output | 1 | Speaker drive: a tone or a steady 0 |

## Verification
The hardest condition to reach from the ports is the one where the digits are corrupted between strobes. The speaker must keep the tone chosen at the last strobe, so the stimulus changes the digits mid-second from a beeping time to a silent one without pulsing `sec_tick`. The other hard part is telling the two tones apart. The bench shortens the divider parameter, walks the time through 59:48 to 00:02 one strobe per second, and counts rising edges of `spk_o` over a fixed window inside each second. That window is an exact multiple of both tone periods, so the count does not depend on the tone's phase. Silent seconds must show no high sample at all.

// File: rtl/chime_pkg.sv
// chime_pkg
// Shared types and decode helpers for the hourly chime generator.
// Assumes the clock supplies valid BCD digits (0..9 each).
package chime_pkg;

    // Which source drives the speaker register
    typedef enum logic [1:0] {
        TONE_MUTE = 2'd0,
        TONE_LOW  = 2'd1,
        TONE_HIGH = 2'd2
    } tone_sel_e;

    // Registered copy of the clock's minute and second digits
    typedef struct packed {
        logic [3:0] mt;
        logic [3:0] mu;
        logic [3:0] st;
        logic [3:0] su;
    } bcd_time_t;

    // Number of tone sources built by the generate loop
    localparam int NUM_TONES = 2;

    // True in the even seconds 50..58 of minute 59
    function automatic logic is_prehour_beep(input bcd_time_t t);
        return (t.mt == 4'd5) && (t.mu == 4'd9) &&
               (t.st == 4'd5) && (t.su[0] == 1'b0);
    endfunction

    // True exactly at minute 00 second 00
    function automatic logic is_on_hour(input bcd_time_t t);
        return (t.mt == 4'd0) && (t.mu == 4'd0) &&
               (t.st == 4'd0) && (t.su == 4'd0);
    endfunction

endpackage

// File: rtl/chime_tone_div.sv
// chime_tone_div
// Free-running square-wave divider: the output toggles after every HALF
// system clock cycles. Assumes HALF >= 2 and that CW can hold HALF-1.
module chime_tone_div #(
    parameter int HALF = 12500,
    parameter int CW   = 15
) (
    input  logic clk,
    input  logic rst_n,
    output logic tone_o
);

    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          tone_q;

    // Count cycles within a half period and flip the tone at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tone_q <= 1'b0;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            tone_q <= ~tone_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tone_o = tone_q;

    // R2/R3: counter never leaves its half-period range
    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R3: the tone only flips right after the last count of a half period
    p_toggle_point_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_q != $past(tone_q)) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/chime_time_latch.sv
// chime_time_latch
// Captures the BCD minute/second digits on the second strobe and records
// that a valid time has been seen since reset. Assumes the digits are
// stable and valid in the cycle sec_tick is high.
module chime_time_latch
    import chime_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [3:0] min_tens,
    input  logic [3:0] min_ones,
    input  logic [3:0] sec_tens,
    input  logic [3:0] sec_ones,
    output bcd_time_t  time_o,
    output logic       valid_o
);

    bcd_time_t time_q;
    logic      valid_q;

    // Sample the digits on the strobe only; hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q  <= '0;
            valid_q <= 1'b0;
        end else if (sec_tick) begin
            time_q  <= '{mt: min_tens, mu: min_ones, st: sec_tens, su: sec_ones};
            valid_q <= 1'b1;
        end
    end

    assign time_o  = time_q;
    assign valid_o = valid_q;

    // R8: without a strobe the captured time does not move
    p_hold_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(time_q) && $stable(valid_q));

    // R8: a strobe always leaves a valid capture behind
    p_valid_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> valid_q);

endmodule

// File: rtl/chime_sched.sv
// chime_sched
// Decodes the captured time into a tone selection: low tone on the even
// seconds from 59:50, high tone at 00:00, mute otherwise and before the
// first capture. Purely combinational; the caller registers the result.
module chime_sched
    import chime_pkg::*;
(
    input  bcd_time_t time_i,
    input  logic      valid_i,
    output tone_sel_e sel_o
);

    // Pick the tone source from the captured time
    always_comb begin
        sel_o = TONE_MUTE;
        if (valid_i) begin
            if (is_on_hour(time_i)) begin
                sel_o = TONE_HIGH;
            end else if (is_prehour_beep(time_i)) begin
                sel_o = TONE_LOW;
            end
        end
    end

    // R4/R6: the two chime windows never overlap
    always_comb begin
        a_disjoint_r4: assert (!(is_on_hour(time_i) && is_prehour_beep(time_i)));
    end

endmodule

// File: rtl/chime_spk_mux.sv
// chime_spk_mux
// Registers the speaker pin from the selected tone source so the pin only
// changes on a clock edge. Assumes tone_i[0] is the low tone, tone_i[1]
// the high tone.
module chime_spk_mux
    import chime_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  tone_sel_e            sel_i,
    input  logic [NUM_TONES-1:0] tone_i,
    output logic                 spk_o
);

    logic spk_q;

    // Drive the speaker from the chosen tone or hold it low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spk_q <= 1'b0;
        end else begin
            unique case (sel_i)
                TONE_LOW:  spk_q <= tone_i[0];
                TONE_HIGH: spk_q <= tone_i[1];
                default:   spk_q <= 1'b0;
            endcase
        end
    end

    assign spk_o = spk_q;

    // R1: reset silences the speaker on the following edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !spk_q);

    // R7: a mute selection yields a low pin one cycle later
    p_mute_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == TONE_MUTE) |=> !spk_q);

    // R4: low selection follows the low tone by one cycle
    p_low_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == TONE_LOW) |=> (spk_q == $past(tone_i[0])));

    // R6: high selection follows the high tone by one cycle
    p_high_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == TONE_HIGH) |=> (spk_q == $past(tone_i[1])));

endmodule

// File: rtl/chime_gen.sv
// chime_gen
// Top of the hourly chime generator: two octave-spaced tone dividers, a
// strobe-sampled time register, the schedule decoder and the registered
// speaker mux. Assumes sec_tick is a single-cycle pulse with valid BCD
// digits alongside it.
module chime_gen
    import chime_pkg::*;
#(
    parameter int LO_HALF = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [3:0] min_tens,
    input  logic [3:0] min_ones,
    input  logic [3:0] sec_tens,
    input  logic [3:0] sec_ones,
    output logic       spk_o
);

    localparam int HI_HALF = LO_HALF / 2;
    localparam int CW      = $clog2(LO_HALF + 1);

    logic [NUM_TONES-1:0] tones;
    bcd_time_t            cap_time;
    logic                 cap_valid;
    tone_sel_e            sel;

    // One divider per tone; index 0 low, index 1 an octave higher
    for (genvar gi = 0; gi < NUM_TONES; gi++) begin : g_tone
        localparam int HALF_I = (gi == 0) ? LO_HALF : HI_HALF;
        chime_tone_div #(
            .HALF (HALF_I),
            .CW   (CW)
        ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .tone_o (tones[gi])
        );
    end

    chime_time_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .sec_tens (sec_tens),
        .sec_ones (sec_ones),
        .time_o   (cap_time),
        .valid_o  (cap_valid)
    );

    chime_sched u_sched (
        .time_i  (cap_time),
        .valid_i (cap_valid),
        .sel_o   (sel)
    );

    chime_spk_mux u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .tone_i (tones),
        .spk_o  (spk_o)
    );

    // R5: odd seconds of minute 59 are always silent at the pin
    p_odd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_time.mt == 4'd5 && cap_time.mu == 4'd9 &&
         cap_time.su[0]) |=> !spk_o);

    // R9: the pin stays low in the cycle right after reset release
    p_first_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !spk_o);

endmodule

// File: tb/sim_chime_gen.sv
// sim_chime_gen
// Scoreboard bench: a driver task plays one second of clock time per call
// and queues the expected rising-edge count; a monitor counts edges in a
// fixed window of each second and compares.
module sim_chime_gen;

    localparam int LO_H   = 10;          // low tone period 20 cycles
    localparam int SEC_CY = 240;         // cycles per simulated second
    localparam int WIN_LO = 20;
    localparam int WIN_HI = 219;         // 200-cycle window
    localparam int EDGE_LO = 10;         // 200 / 20
    localparam int EDGE_HI = 20;         // 200 / 10

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [3:0] min_tens = '0, min_ones = '0, sec_tens = '0, sec_ones = '0;
    logic       spk_o;

    int total = 0;
    int bad   = 0;

    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    chime_gen #(.LO_HALF(LO_H)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .sec_tens (sec_tens),
        .sec_ones (sec_ones),
        .spk_o    (spk_o)
    );

    // Driver: one second; optionally corrupt digits mid-second without a tick
    task automatic play_sec(input int mt, input int mu, input int st, input int su,
                            input int exp_edges, input string tag,
                            input bit corrupt = 1'b0);
        exp_q.push_back(exp_edges);
        tag_q.push_back(tag);
        @(posedge clk); #2;
        min_tens = 4'(mt); min_ones = 4'(mu);
        sec_tens = 4'(st); sec_ones = 4'(su);
        sec_tick = 1'b1;
        @(posedge clk); #2;
        sec_tick = 1'b0;
        for (int i = 0; i < SEC_CY - 2; i++) begin
            @(posedge clk);
            if (corrupt && i == 5) begin
                #2;
                min_tens = 4'd0; min_ones = 4'd0;
                sec_tens = 4'd0; sec_ones = 4'd1;
            end
        end
    endtask

    // Monitor: count rising edges and high samples inside each second's window
    int  phase = -1;
    int  edges = 0;
    int  highs = 0;
    logic prev_spk = 1'b0;
    always @(negedge clk) begin
        if (sec_tick) begin
            phase = 0;
            edges = 0;
            highs = 0;
        end else if (phase >= 0) begin
            phase = phase + 1;
        end
        if (phase >= WIN_LO && phase <= WIN_HI) begin
            if (spk_o && !prev_spk && phase > WIN_LO) edges = edges + 1;
            if (spk_o) highs = highs + 1;
        end
        if (phase == WIN_HI) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (edges != e || (e == 0 && highs != 0)) begin
                bad++;
                $display("FAIL %s: edges=%0d highs=%0d expected edges=%0d", t, edges, highs, e);
            end
            phase = -1;
        end
        prev_spk = spk_o;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Stimulus
    initial begin
        int ones_seen;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: no tick yet, speaker must stay low even though digits read 00:00
        ones_seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (spk_o) ones_seen++;
        end
        total++;
        if (ones_seen != 0) begin
            bad++;
            $display("FAIL R1: high samples=%0d expected=0", ones_seen);
        end

        play_sec(5, 8, 5, 0, 0, "R7 58:50");
        play_sec(5, 9, 4, 8, 0, "R7 59:48");
        play_sec(5, 9, 4, 9, 0, "R7 59:49");
        play_sec(5, 9, 5, 0, EDGE_LO, "R4 R2 R9 59:50");
        play_sec(5, 9, 5, 1, 0, "R5 59:51");
        play_sec(5, 9, 5, 2, EDGE_LO, "R4 59:52");
        play_sec(5, 9, 5, 3, 0, "R5 59:53");
        play_sec(5, 9, 5, 4, EDGE_LO, "R4 59:54");
        play_sec(5, 9, 5, 5, 0, "R5 59:55");
        play_sec(5, 9, 5, 6, EDGE_LO, "R4 59:56");
        play_sec(5, 9, 5, 7, 0, "R5 59:57");
        play_sec(5, 9, 5, 8, EDGE_LO, "R4 59:58");
        play_sec(5, 9, 5, 9, 0, "R5 59:59");
        play_sec(0, 0, 0, 0, EDGE_HI, "R6 R3 00:00");
        play_sec(0, 0, 0, 1, 0, "R7 00:01");
        play_sec(0, 0, 0, 2, 0, "R7 00:02");
        play_sec(1, 0, 0, 0, 0, "R7 10:00");
        play_sec(5, 9, 5, 6, EDGE_LO, "R8 59:56 digits corrupted mid-second", 1'b1);
        play_sec(0, 0, 0, 0, EDGE_HI, "R6 00:00 again");

        repeat (10) @(posedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R9: pending results=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule